// File: doc/BRIEF.md
# Bulk Command Register-Write Decoder

This block sits on a byte stream of bulk commands and turns the register-write commands it finds into updates of a bank of 8-bit video control registers. Each command opens with a prefix byte and a command code. A write command then carries a register index and a data byte. A pixel-copy command has a fixed-length payload, which the block reads in and discards so that the payload bytes are never taken as commands. Any other code raises an error flag that stays set, and the decoder then waits for the next prefix before it decodes again.

The registers are held twice. Writes always go to a staging copy. While the bank is unlocked they also go straight to the live copy. A write of the lock value to the control index freezes the live copy. A later write of the unlock value copies the whole staging copy into the live copy on one clock edge, so a full mode change appears downstream all at once. The live copy drives the timing and frame-buffer fields that downstream logic uses. Most 16-bit fields take their high byte at the lower index. The pixel clock field takes its low byte at the lower index. A combinational read port returns any live register.

Top module: `bulk_regwr_decoder`

## Requirements
- R1: After reset, every live register and every field output reads 0, `locked` and `err_flag` are 0, and `in_ready` is 1 from the first clock after reset is released.
- R2: The sequence 0xAF, 0x20, index, value writes value to the register at index. The written value is visible on `rd_data` (with `rd_idx` = index) right after the clock edge that accepts the value byte.
- R3: While unlocked, a write reaches the live bank on that same edge, including a write that follows an unlock command with no gap.
- R4: Writing 0x00 to control index 0xFF sets `locked`. While locked, register writes leave every live register and field output unchanged.
- R5: Writing 0xFF to control index 0xFF clears `locked` and copies every staged register into the live bank on one edge.
- R6: `h_pixels` is built from registers 0x0F (high byte) and 0x10 (low byte). `v_pixels` is built from 0x17 (high byte) and 0x18 (low byte).
- R7: `pix_clk_5k` is built from register 0x1B (low byte) and 0x1C (high byte).
- R8: `fb16_base` is built from registers 0x20, 0x21 and 0x22, with 0x20 as the most significant byte. `fb8_base` is built from 0x26, 0x27 and 0x28, with 0x26 as the most significant byte.
- R9: After 0xAF, 0x6A, the next 7 bytes are discarded whatever their values, and no register changes.
- R10: A 0xAF in the command-code position is taken as a fresh prefix and sets no error. A lone trailing 0xAF changes nothing.
- R11: A command code other than 0x20, 0x6A or 0xAF sets `err_flag`, which stays set until reset. Bytes after it are ignored until the next 0xAF.
- R12: A byte is consumed only on a clock edge where `in_valid` is 1. Idle cycles between the bytes of a command do not change the result.
- R13: A control write with a value other than 0x00 or 0xFF is ignored. A write to an index of NUM_REGS (64) or above, other than the control index, is ignored, and `rd_data` reads 0 for such an index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command stream byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| rd_idx | input | 8 | Live register index to read |
| rd_data | output | 8 | Live register value at rd_idx |
| h_pixels | output | 16 | Visible pixels per line |
| v_pixels | output | 16 | Visible lines per frame |
| pix_clk_5k | output | 16 | Pixel clock in 5 kHz units |
| fb16_base | output | 24 | 16bpp frame buffer base address |
| fb8_base | output | 24 | 8bpp frame buffer base address |
| locked | output | 1 | Live bank frozen, writes staged only |
| err_flag | output | 1 | Sticky unknown-command flag |

## Verification
Two events can share one clock edge. One is the unlock copy, which rewrites the whole live bank and clears the lock. The other is a direct write to both banks, which follows the unlock with no idle cycle. The bench sends an unlock command and then a register write back to back. It then checks that the field holds the value copied in by the unlock and also the byte written directly afterwards, and that the direct write was not lost or overwritten. A second case writes while unlocked, then locks and unlocks without rewriting. The field must stay the same, which shows that the direct write also reached the staging copy.

// File: rtl/bulkdec_pkg.sv
package bulkdec_pkg;

  localparam logic [7:0] PREFIX_BYTE = 8'hAF;
  localparam logic [7:0] CODE_REGWR  = 8'h20;
  localparam logic [7:0] CODE_COPY16 = 8'h6A;
  localparam int         COPY_BYTES  = 7;

  localparam logic [7:0] CTRL_IDX   = 8'hFF;
  localparam logic [7:0] CTRL_LOCK  = 8'h00;
  localparam logic [7:0] CTRL_APPLY = 8'hFF;

  localparam int HPIX_IDX = 'h0F;
  localparam int VPIX_IDX = 'h17;
  localparam int PCLK_IDX = 'h1B;
  localparam int FB16_IDX = 'h20;
  localparam int FB8_IDX  = 'h26;

  typedef enum logic [2:0] {
    PS_HUNT,
    PS_CODE,
    PS_INDEX,
    PS_VALUE,
    PS_SKIP
  } parse_state_t;

  function automatic logic idx_in_bank(input logic [7:0] idx, input int nregs);
    return int'(idx) < nregs;
  endfunction

  function automatic int skip_reload(input int payload);
    return payload - 1;
  endfunction

  // byte lane inside a multi-byte field for register offset k
  function automatic int lane_of(input int k, input int nbytes, input logic msb_first);
    return msb_first ? (nbytes - 1 - k) : k;
  endfunction

endpackage

// File: rtl/bulk_cmd_parser.sv
module bulk_cmd_parser
  import bulkdec_pkg::*;
#(
  parameter logic [7:0] PREFIX   = PREFIX_BYTE,
  parameter logic [7:0] WR_CODE  = CODE_REGWR,
  parameter logic [7:0] CPY_CODE = CODE_COPY16,
  parameter int         CPY_LEN  = COPY_BYTES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       wr_fire,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       err_fire,
  output logic       err_flag
);

  localparam int CW = (CPY_LEN > 1) ? $clog2(CPY_LEN) : 1;

  parse_state_t  st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    idx_q, idx_d;
  logic          rdy_q, err_q;
  logic          take;

  assign take     = in_valid && rdy_q;
  assign in_ready = rdy_q;
  assign err_flag = err_q;
  assign wr_idx   = idx_q;
  assign wr_data  = in_data;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    wr_fire  = 1'b0;
    err_fire = 1'b0;
    if (take) begin
      case (st_q)
        PS_HUNT: begin
          if (in_data == PREFIX) st_d = PS_CODE;
        end
        PS_CODE: begin
          if (in_data == PREFIX) begin
            st_d = PS_CODE;
          end else if (in_data == WR_CODE) begin
            st_d = PS_INDEX;
          end else if (in_data == CPY_CODE) begin
            st_d  = PS_SKIP;
            cnt_d = CW'(skip_reload(CPY_LEN));
          end else begin
            err_fire = 1'b1;
            st_d     = PS_HUNT;
          end
        end
        PS_INDEX: begin
          idx_d = in_data;
          st_d  = PS_VALUE;
        end
        PS_VALUE: begin
          wr_fire = 1'b1;
          st_d    = PS_HUNT;
        end
        PS_SKIP: begin
          if (cnt_q == '0) st_d = PS_HUNT;
          else             cnt_d = cnt_q - 1'b1;
        end
        default: st_d = PS_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_HUNT;
      cnt_q <= '0;
      idx_q <= '0;
      rdy_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      rdy_q <= 1'b1;
      if (err_fire) err_q <= 1'b1;
    end
  end

endmodule

// File: rtl/vreg_dual_bank.sv
module vreg_dual_bank
  import bulkdec_pkg::*;
#(
  parameter int         NUM_REGS = 64,
  parameter logic [7:0] CTL_IDX  = CTRL_IDX,
  parameter logic [7:0] LOCK_VAL = CTRL_LOCK,
  parameter logic [7:0] APPLY_VAL = CTRL_APPLY
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] live_flat,
  output logic                  locked,
  output logic                  lock_fire,
  output logic                  commit_fire
);

  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic          locked_q;
  logic          data_hit;
  logic [IW-1:0] wr_slot, rd_slot;

  assign lock_fire   = wr_fire && (wr_idx == CTL_IDX) && (wr_data == LOCK_VAL);
  assign commit_fire = wr_fire && (wr_idx == CTL_IDX) && (wr_data == APPLY_VAL);
  assign data_hit    = wr_fire && (wr_idx != CTL_IDX) && idx_in_bank(wr_idx, NUM_REGS);
  assign wr_slot     = wr_idx[IW-1:0];
  assign rd_slot     = rd_idx[IW-1:0];
  assign locked      = locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           locked_q <= 1'b0;
    else if (lock_fire)   locked_q <= 1'b1;
    else if (commit_fire) locked_q <= 1'b0;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] stage_q;
    logic [7:0] live_q;
    logic       sel;
    assign sel = data_hit && (wr_slot == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        live_q  <= '0;
      end else begin
        if (sel) stage_q <= wr_data;
        if (commit_fire)            live_q <= stage_q;
        else if (sel && !locked_q)  live_q <= wr_data;
      end
    end
    assign live_flat[g*8 +: 8] = live_q;
  end

  always_comb begin
    rd_data = '0;
    if (idx_in_bank(rd_idx, NUM_REGS)) rd_data = live_flat[rd_slot*8 +: 8];
  end

endmodule

// File: rtl/vreg_field_tap.sv
module vreg_field_tap
  import bulkdec_pkg::*;
#(
  parameter int   NUM_REGS  = 64,
  parameter int   BASE      = 0,
  parameter int   NBYTES    = 2,
  parameter logic MSB_FIRST = 1'b1
) (
  input  logic [NUM_REGS*8-1:0] live_flat,
  output logic [NBYTES*8-1:0]   value
);

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    localparam int LANE = lane_of(k, NBYTES, MSB_FIRST);
    assign value[LANE*8 +: 8] = live_flat[(BASE+k)*8 +: 8];
  end

endmodule

// File: rtl/bulk_regwr_decoder.sv
module bulk_regwr_decoder
  import bulkdec_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int CPY_LEN  = COPY_BYTES
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  input  logic [7:0]  rd_idx,
  output logic [7:0]  rd_data,
  output logic [15:0] h_pixels,
  output logic [15:0] v_pixels,
  output logic [15:0] pix_clk_5k,
  output logic [23:0] fb16_base,
  output logic [23:0] fb8_base,
  output logic        locked,
  output logic        err_flag
);

  logic                  wr_fire, err_fire, lock_fire, commit_fire;
  logic [7:0]            wr_idx, wr_data;
  logic [NUM_REGS*8-1:0] live_flat;

  bulk_cmd_parser #(.CPY_LEN(CPY_LEN)) u_parse (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data),
    .err_fire(err_fire), .err_flag(err_flag)
  );

  vreg_dual_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .live_flat(live_flat),
    .locked(locked), .lock_fire(lock_fire), .commit_fire(commit_fire)
  );

  vreg_field_tap #(.NUM_REGS(NUM_REGS), .BASE(HPIX_IDX), .NBYTES(2), .MSB_FIRST(1'b1))
    u_hpix (.live_flat(live_flat), .value(h_pixels));
  vreg_field_tap #(.NUM_REGS(NUM_REGS), .BASE(VPIX_IDX), .NBYTES(2), .MSB_FIRST(1'b1))
    u_vpix (.live_flat(live_flat), .value(v_pixels));
  vreg_field_tap #(.NUM_REGS(NUM_REGS), .BASE(PCLK_IDX), .NBYTES(2), .MSB_FIRST(1'b0))
    u_pclk (.live_flat(live_flat), .value(pix_clk_5k));
  vreg_field_tap #(.NUM_REGS(NUM_REGS), .BASE(FB16_IDX), .NBYTES(3), .MSB_FIRST(1'b1))
    u_fb16 (.live_flat(live_flat), .value(fb16_base));
  vreg_field_tap #(.NUM_REGS(NUM_REGS), .BASE(FB8_IDX), .NBYTES(3), .MSB_FIRST(1'b1))
    u_fb8 (.live_flat(live_flat), .value(fb8_base));

endmodule

// File: rtl/bulk_regwr_decoder_chk.sv
module bulk_regwr_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_fire,
  input logic [7:0]  wr_idx,
  input logic [7:0]  wr_data,
  input logic        err_fire,
  input logic        commit_fire,
  input logic        lock_fire,
  input logic        locked,
  input logic        err_flag,
  input logic [15:0] h_pixels,
  input logic [15:0] pix_clk_5k,
  input logic [23:0] fb16_base
);

  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    err_fire |=> err_flag); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R11

  AST_LOCK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fire |=> locked); // R4

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !commit_fire) |=> ($stable(h_pixels) && $stable(fb16_base) && $stable(pix_clk_5k))); // R4

  AST_COMMIT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> !locked); // R5

  AST_FB16_MSB_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !locked && wr_idx == 8'h20) |=> (fb16_base[23:16] == $past(wr_data))); // R8

  AST_PCLK_LOW_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !locked && wr_idx == 8'h1B) |=> (pix_clk_5k[7:0] == $past(wr_data))); // R7

endmodule

bind bulk_regwr_decoder bulk_regwr_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data),
  .err_fire(err_fire), .commit_fire(commit_fire), .lock_fire(lock_fire),
  .locked(locked), .err_flag(err_flag),
  .h_pixels(h_pixels), .pix_clk_5k(pix_clk_5k), .fb16_base(fb16_base)
);

// File: tb/test_bulk_regwr_decoder.sv
`timescale 1ns/1ps
module test_bulk_regwr_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic [7:0]  rd_idx = 8'h00;
  logic [7:0]  rd_data;
  logic [15:0] h_pixels, v_pixels, pix_clk_5k;
  logic [23:0] fb16_base, fb8_base;
  logic        locked, err_flag;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  bulk_regwr_decoder i_bulk_regwr_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_idx(rd_idx), .rd_data(rd_data),
    .h_pixels(h_pixels), .v_pixels(v_pixels), .pix_clk_5k(pix_clk_5k),
    .fb16_base(fb16_base), .fb8_base(fb8_base),
    .locked(locked), .err_flag(err_flag)
  );

  // {index, value, expected read-back}; bank holds 64 registers
  localparam logic [23:0] VECS [8] = '{
    24'h01_5A_5A, 24'h05_C3_C3, 24'h3F_81_81, 24'h40_77_00,
    24'h80_12_00, 24'h00_FE_FE, 24'h0A_AF_AF, 24'h30_20_20
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] val);
    send(8'hAF); send(8'h20); send(idx); send(val);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "locked", locked, 0);
    chk("R1", "err_flag", err_flag, 0);
    chk("R1", "fields", {h_pixels, v_pixels} | pix_clk_5k | fb16_base | fb8_base, 0);

    // R2 / R13 vector walk: write then read back
    foreach (VECS[i]) begin
      wr(VECS[i][23:16], VECS[i][15:8]);
      rd_idx = VECS[i][23:16];
      #1;
      chk("R2_R13", "read back", rd_data, VECS[i][7:0]);
    end

    // R6 high byte first
    wr(8'h0F, 8'h05); wr(8'h10, 8'h00);
    chk("R6", "h_pixels", h_pixels, 16'h0500);
    wr(8'h17, 8'h03); wr(8'h18, 8'h20);
    chk("R6", "v_pixels", v_pixels, 16'h0320);
    // R7 low byte first
    wr(8'h1B, 8'h34); wr(8'h1C, 8'h12);
    chk("R7", "pix_clk_5k", pix_clk_5k, 16'h1234);
    // R8 24-bit bases
    wr(8'h20, 8'h0A); wr(8'h21, 8'h0B); wr(8'h22, 8'h0C);
    chk("R8", "fb16_base", fb16_base, 24'h0A0B0C);
    wr(8'h26, 8'h01); wr(8'h27, 8'h02); wr(8'h28, 8'h03);
    chk("R8", "fb8_base", fb8_base, 24'h010203);

    // R4 lock freezes live bank
    wr(8'hFF, 8'h00);
    chk("R4", "locked", locked, 1);
    wr(8'h20, 8'h77); wr(8'h10, 8'h99);
    rd_idx = 8'h20; #1;
    chk("R4", "fb16_base frozen", fb16_base, 24'h0A0B0C);
    chk("R4", "h_pixels frozen", h_pixels, 16'h0500);
    chk("R4", "rd_data frozen", rd_data, 8'h0A);
    // R13 other control value ignored
    wr(8'hFF, 8'h55);
    chk("R13", "still locked", locked, 1);

    // R5 unlock commits, R3 back-to-back direct write
    wr(8'hFF, 8'hFF);
    chk("R5", "unlocked", locked, 0);
    chk("R5", "fb16_base applied", fb16_base, 24'h770B0C);
    chk("R5", "h_pixels applied", h_pixels, 16'h0599);
    wr(8'h21, 8'h44);
    chk("R3", "direct after unlock", fb16_base, 24'h77440C);
    // R3 direct write also staged: lock/unlock without rewrite keeps it
    wr(8'hFF, 8'h00); wr(8'hFF, 8'hFF);
    chk("R3", "staged copy kept", fb16_base, 24'h77440C);

    // R9 copy payload skipped even if it looks like commands
    send(8'hAF); send(8'h6A);
    send(8'hAF); send(8'h20); send(8'h21); send(8'h99);
    send(8'hAF); send(8'h20); send(8'h00);
    chk("R9", "fb16_base untouched", fb16_base, 24'h77440C);
    wr(8'h22, 8'h55);
    chk("R9", "resync after copy", fb16_base, 24'h774455);
    chk("R9", "no error", err_flag, 0);

    // R10 padding prefix
    send(8'hAF); send(8'hAF); send(8'h20); send(8'h26); send(8'h09);
    chk("R10", "double prefix write", fb8_base, 24'h090203);
    send(8'hAF);
    chk("R10", "lone prefix no error", err_flag, 0);
    chk("R10", "lone prefix no change", fb8_base, 24'h090203);

    // R12 idle gaps with junk data on the bus
    send(8'hAF);
    in_data = 8'h55; repeat (3) @(negedge clk);
    send(8'h20);
    in_data = 8'hAF; repeat (2) @(negedge clk);
    send(8'h27); send(8'h88);
    chk("R12", "gapped write", fb8_base, 24'h098803);
    chk("R12", "no error", err_flag, 0);

    // R11 unknown code
    send(8'hAF); send(8'h13);
    chk("R11", "err set", err_flag, 1);
    send(8'h20); send(8'h28); send(8'h66);
    chk("R11", "junk ignored", fb8_base, 24'h098803);
    wr(8'h28, 8'h66);
    chk("R11", "resync on prefix", fb8_base, 24'h098866);
    chk("R11", "err sticky", err_flag, 1);

    // R1 reset again clears everything
    do_reset();
    chk("R1", "err cleared", err_flag, 0);
    chk("R1", "fb8 cleared", fb8_base, 0);
    chk("R1", "fb16 cleared", fb16_base, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule